// File: doc/BRIEF.md
# Multi-Buffer Circular Address Generator

This block produces data memory addresses for up to eight independent circular buffers, so that each stage of a cascaded filter (one biquad after another, say) can keep its own delay line. Each buffer owns four registers: a current index, a signed step, a length and a base. When a request arrives, the generator returns the selected buffer's current index as the address. In the same cycle it writes back the stepped index. The processor spends no extra cycles on pointer bookkeeping, because the access and the pointer update happen together.

Two update rules are offered per request. The circular rule adds the step and folds the result back into the window from base to base plus length minus one. A length of zero turns folding off, which gives a plain linear post-modify. The bit-reversed rule adds the step with the carry running from the high bit of a programmable window toward bit zero. This yields the scrambled order used by radix-2 FFT passes. Bits above the window stay as they are.

Software loads the registers through a narrow write port, one field per cycle. The address appears on a registered output one clock after the request.

Top module: `circ_addr_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `addr_valid` is 0. Reset clears every register of every buffer to zero.
- R2: `addr_valid` is 1 in exactly the cycle after a cycle with `req_valid` high. `addr_out` then equals the selected buffer's index as it was before that request's update (post-modify).
- R3: In circular mode (`req_mode`=0) with nonzero length, when index plus step stays inside [base, base+length-1], the new index is index plus step. The step is read as two's complement.
- R4: In circular mode, when index plus step is at or above base+length, the new index is index plus step minus length.
- R5: In circular mode, when index plus step is below base, the new index is index plus step plus length. R4 and R5 assume |step| <= length.
- R6: In circular mode with length 0, the new index is index plus step modulo 2^AW, with no range check.
- R7: In bit-reversed mode (`req_mode`=1), the low n bits of the index are added to the low n bits of the step with the carry running from bit n-1 down to bit 0. Bits at position n and above are kept. Here n is `rev_bits`; a value of 0 or above AW means n=AW.
- R8: A request changes only the selected buffer's index. Every other buffer's registers are untouched.
- R9: Config writes use the field code in `cfg_field`: 0 index, 1 step, 2 length, 3 base. A write is seen by the next request to that buffer.
- R10: If a config write to the index field and a request target the same buffer in the same cycle, the request still outputs the old index, and the written value replaces the stepped one.
- R11: One request per cycle is accepted with no stall. In a cycle after no request, `addr_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_buf | input | SELW | Buffer written by the config port |
| cfg_field | input | 2 | Field code: 0 index, 1 step, 2 length, 3 base |
| cfg_data | input | AW | Config write value |
| req_valid | input | 1 | Address request and update strobe |
| req_buf | input | SELW | Buffer selected for the request |
| req_mode | input | 1 | 0 circular, 1 bit-reversed |
| rev_bits | input | NBW | Bit-reversed window width |
| addr_valid | output | 1 | Address output valid |
| addr_out | output | AW | Registered address (pre-update index) |

## Verification
The bench aims at the folding edges. It steps exactly onto base+length to catch an off-by-one or a wrong comparison direction, where a faulty design would emit base+length or fail to fold. It takes a negative step below base, where a design that ignores the sign would run away upward. It uses length 0 over the top of the address space, where a faulty design would fold or stick instead of rolling to zero. In bit-reversed mode it checks window widths of 3 and of full width, and checks that the upper bits survive; a carry running the wrong way yields linear counting. It also interleaves two buffers, which exposes a shared or wrongly indexed register set. It hits a config write and a request in the same cycle, where a wrong priority leaks the stepped value or outputs the new index too early.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;
  typedef enum logic [1:0] {
    FLD_INDEX  = 2'd0,
    FLD_STEP   = 2'd1,
    FLD_LENGTH = 2'd2,
    FLD_BASE   = 2'd3
  } cfg_field_e;

  typedef enum logic {
    MODE_CIRC   = 1'b0,
    MODE_BITREV = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/circ_regfile.sv
module circ_regfile #(
  parameter int AW   = 16,
  parameter int NBUF = 8,
  parameter int SELW = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_buf,
  input  logic [1:0]      cfg_field,
  input  logic [AW-1:0]   cfg_data,
  input  logic            upd_we,
  input  logic [SELW-1:0] upd_buf,
  input  logic [AW-1:0]   upd_idx,
  input  logic [SELW-1:0] rd_buf,
  output logic [AW-1:0]   rd_idx,
  output logic [AW-1:0]   rd_step,
  output logic [AW-1:0]   rd_len,
  output logic [AW-1:0]   rd_base
);
  import circ_agen_pkg::*;

  logic [AW-1:0] idx_q  [NBUF];
  logic [AW-1:0] step_q [NBUF];
  logic [AW-1:0] len_q  [NBUF];
  logic [AW-1:0] base_q [NBUF];

  cfg_field_e fld;
  assign fld = cfg_field_e'(cfg_field);

  // Config write is placed after the update so it wins on the index field.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBUF; i++) begin
        idx_q[i]  <= '0;
        step_q[i] <= '0;
        len_q[i]  <= '0;
        base_q[i] <= '0;
      end
    end else begin
      if (upd_we) idx_q[upd_buf] <= upd_idx;
      if (cfg_we) begin
        case (fld)
          FLD_INDEX:  idx_q[cfg_buf]  <= cfg_data;
          FLD_STEP:   step_q[cfg_buf] <= cfg_data;
          FLD_LENGTH: len_q[cfg_buf]  <= cfg_data;
          FLD_BASE:   base_q[cfg_buf] <= cfg_data;
          default:    ;
        endcase
      end
    end
  end

  assign rd_idx  = idx_q[rd_buf];
  assign rd_step = step_q[rd_buf];
  assign rd_len  = len_q[rd_buf];
  assign rd_base = base_q[rd_buf];
endmodule

// File: rtl/circ_wrap_unit.sv
module circ_wrap_unit #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] nxt
);
  localparam int XW = AW + 2;

  logic signed [XW-1:0] sum, lo_lim, hi_lim, len_x, folded;

  always_comb begin
    sum    = $signed({2'b00, idx}) + $signed({{2{step[AW-1]}}, step});
    len_x  = $signed({2'b00, len});
    lo_lim = $signed({2'b00, base});
    hi_lim = lo_lim + len_x;
    if (len == '0)          folded = sum;
    else if (sum >= hi_lim) folded = sum - len_x;
    else if (sum < lo_lim)  folded = sum + len_x;
    else                    folded = sum;
    nxt = folded[AW-1:0];
  end
endmodule

// File: rtl/circ_bitrev_unit.sv
module circ_bitrev_unit #(
  parameter int AW  = 16,
  parameter int NBW = $clog2(AW + 1)
) (
  input  logic [AW-1:0]  idx,
  input  logic [AW-1:0]  step,
  input  logic [NBW-1:0] nbits,
  output logic [AW-1:0]  nxt
);
  logic [NBW-1:0] n_eff;
  logic [AW-1:0]  win_mask, r_idx, r_step, r_sum, back;

  assign n_eff = (nbits == '0 || nbits > NBW'(AW)) ? NBW'(AW) : nbits;

  for (genvar g = 0; g < AW; g++) begin : g_mask
    assign win_mask[g] = (NBW'(g) < n_eff);
  end

  function automatic logic [AW-1:0] rev_win(input logic [AW-1:0] x,
                                            input logic [NBW-1:0] n);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < AW; i++)
      if (i < int'(n)) r[i] = x[int'(n) - 1 - i];
    return r;
  endfunction

  always_comb begin
    r_idx  = rev_win(idx, n_eff);
    r_step = rev_win(step, n_eff);
    r_sum  = (r_idx + r_step) & win_mask;
    back   = rev_win(r_sum, n_eff);
    nxt    = (idx & ~win_mask) | (back & win_mask);
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int AW   = 16,
  parameter int NBUF = 8,
  parameter int SELW = $clog2(NBUF),
  parameter int NBW  = $clog2(AW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_buf,
  input  logic [1:0]      cfg_field,
  input  logic [AW-1:0]   cfg_data,
  input  logic            req_valid,
  input  logic [SELW-1:0] req_buf,
  input  logic            req_mode,
  input  logic [NBW-1:0]  rev_bits,
  output logic            addr_valid,
  output logic [AW-1:0]   addr_out
);
  import circ_agen_pkg::*;

  logic [AW-1:0] rd_idx, rd_step, rd_len, rd_base;
  logic [AW-1:0] wrap_nxt, rev_nxt, nxt_idx;

  circ_regfile #(.AW(AW), .NBUF(NBUF), .SELW(SELW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_buf(cfg_buf), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .upd_we(req_valid), .upd_buf(req_buf), .upd_idx(nxt_idx),
    .rd_buf(req_buf),
    .rd_idx(rd_idx), .rd_step(rd_step), .rd_len(rd_len), .rd_base(rd_base)
  );

  circ_wrap_unit #(.AW(AW)) u_wrap (
    .idx(rd_idx), .step(rd_step), .len(rd_len), .base(rd_base), .nxt(wrap_nxt)
  );

  circ_bitrev_unit #(.AW(AW), .NBW(NBW)) u_brev (
    .idx(rd_idx), .step(rd_step), .nbits(rev_bits), .nxt(rev_nxt)
  );

  assign nxt_idx = (upd_mode_e'(req_mode) == MODE_BITREV) ? rev_nxt : wrap_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) addr_out <= rd_idx;
    end
  end
endmodule

// File: rtl/circ_agen_chk.sv
module circ_agen_chk #(
  parameter int AW  = 16,
  parameter int NBW = $clog2(AW + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_mode,
  input logic [NBW-1:0] rev_bits,
  input logic           addr_valid,
  input logic [AW-1:0]  addr_out,
  input logic [AW-1:0]  cur_idx,
  input logic [AW-1:0]  cur_step,
  input logic [AW-1:0]  cur_len,
  input logic [AW-1:0]  cur_base,
  input logic [AW-1:0]  nxt_idx
);
  logic [AW:0]    lo_w, hi_w, idx_w, nxt_w, mag_w;
  logic [NBW-1:0] n_eff;
  logic [AW-1:0]  hi_mask;
  logic           in_win;

  always_comb begin
    lo_w    = {1'b0, cur_base};
    hi_w    = {1'b0, cur_base} + {1'b0, cur_len};
    idx_w   = {1'b0, cur_idx};
    nxt_w   = {1'b0, nxt_idx};
    mag_w   = cur_step[AW-1] ? {1'b0, -cur_step} : {1'b0, cur_step};
    in_win  = (cur_len != '0) && !hi_w[AW] && (idx_w >= lo_w) && (idx_w < hi_w)
              && (mag_w <= {1'b0, cur_len});
    n_eff   = (rev_bits == '0 || rev_bits > NBW'(AW)) ? NBW'(AW) : rev_bits;
    hi_mask = {AW{1'b1}} << n_eff;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !addr_valid);

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid);

  assert_no_valid_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid);

  assert_addr_is_old_index_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (addr_out == $past(cur_idx)));

  assert_wrap_stays_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_mode && in_win) |-> (nxt_w >= lo_w && nxt_w < hi_w));

  assert_bitrev_upper_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode) |-> ((nxt_idx & hi_mask) == (cur_idx & hi_mask)));

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(addr_out));
endmodule

bind circ_addr_gen circ_agen_chk #(.AW(AW), .NBW(NBW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
  .rev_bits(rev_bits), .addr_valid(addr_valid), .addr_out(addr_out),
  .cur_idx(rd_idx), .cur_step(rd_step), .cur_len(rd_len), .cur_base(rd_base),
  .nxt_idx(nxt_idx)
);

// File: tb/circ_addr_gen_bench.sv
module circ_addr_gen_bench;
  localparam int AW = 16, NBUF = 8, SELW = 3, NBW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_we = 1'b0;
  logic [SELW-1:0] cfg_buf = '0;
  logic [1:0]      cfg_field = '0;
  logic [AW-1:0]   cfg_data = '0;
  logic            req_valid = 1'b0;
  logic [SELW-1:0] req_buf = '0;
  logic            req_mode = 1'b0;
  logic [NBW-1:0]  rev_bits = '0;
  logic            addr_valid;
  logic [AW-1:0]   addr_out;

  always #5 clk = ~clk;

  circ_addr_gen u_circ_addr_gen (.*);

  typedef struct { bit v; logic [AW-1:0] a; string tag; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] last_addr = '0;
  logic [AW-1:0] m_idx [NBUF], m_step [NBUF], m_len [NBUF], m_base [NBUF];

  function automatic logic [AW-1:0] wrap_model(int b);
    int s, lo, hi;
    s  = int'(m_idx[b]) + int'($signed(m_step[b]));
    lo = int'(m_base[b]);
    hi = lo + int'(m_len[b]);
    if (m_len[b] != 0) begin
      if (s >= hi) s = s - int'(m_len[b]);
      else if (s < lo) s = s + int'(m_len[b]);
    end
    return AW'(s);
  endfunction

  function automatic logic [AW-1:0] brev_model(int b, int n);
    logic [AW-1:0] r;
    logic [1:0] s;
    logic c;
    int w;
    w = (n == 0 || n > AW) ? AW : n;
    r = m_idx[b];
    c = 1'b0;
    for (int k = w - 1; k >= 0; k--) begin
      s = 2'(m_idx[b][k]) + 2'(m_step[b][k]) + 2'(c);
      r[k] = s[0];
      c = s[1];
    end
    return r;
  endfunction

  task automatic put(bit v, logic [AW-1:0] a, string tag);
    item_t it;
    it.v = v; it.a = a; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cfg(int b, int f, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_buf = SELW'(b); cfg_field = 2'(f); cfg_data = d; req_valid = 0;
    case (f)
      0: m_idx[b] = d;
      1: m_step[b] = d;
      2: m_len[b] = d;
      default: m_base[b] = d;
    endcase
    put(0, last_addr, "R9");
  endtask

  task automatic setup(int b, logic [AW-1:0] base, logic [AW-1:0] len,
                       logic [AW-1:0] step, logic [AW-1:0] idx);
    cfg(b, 3, base); cfg(b, 2, len); cfg(b, 1, step); cfg(b, 0, idx);
  endtask

  task automatic req(int b, bit mode, int n, string tag);
    @(negedge clk);
    cfg_we = 0; req_valid = 1; req_buf = SELW'(b); req_mode = mode; rev_bits = NBW'(n);
    put(1, m_idx[b], tag);
    last_addr = m_idx[b];
    m_idx[b] = mode ? brev_model(b, n) : wrap_model(b);
  endtask

  task automatic req_and_write(int b, logic [AW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_buf = SELW'(b); req_mode = 0; rev_bits = '0;
    cfg_we = 1; cfg_buf = SELW'(b); cfg_field = 2'd0; cfg_data = d;
    put(1, m_idx[b], "R10");
    last_addr = m_idx[b];
    m_idx[b] = d;
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    put(0, last_addr, "R11");
  endtask

  // Monitor: one item per cycle, sampled well after the rising edge.
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (addr_valid !== it.v || addr_out !== it.a) begin
          n_fail++;
          $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
                   it.tag, addr_valid, addr_out, it.v, it.a);
        end
      end else if (addr_valid !== 1'b0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: valid=%0b expected valid=0 with no request", addr_valid);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBUF; i++) begin
      m_idx[i] = '0; m_step[i] = '0; m_len[i] = '0; m_base[i] = '0;
    end
    repeat (3) @(negedge clk);
    n_chk++;
    if (addr_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: valid=%0b expected 0 in reset", addr_valid);
    end
    rst = 0;
    // R1: registers cleared, step zero keeps index at zero
    req(5, 0, 0, "R1"); req(5, 0, 0, "R1"); idle();
    // R3, R4: upward fold landing exactly on base+length
    setup(0, 16'd100, 16'd10, 16'd3, 16'd100);
    for (int k = 0; k < 6; k++) req(0, 0, 0, "R4");
    idle();
    // R5: negative step below base
    setup(1, 16'd200, 16'd8, 16'hFFFD, 16'd201);
    for (int k = 0; k < 5; k++) req(1, 0, 0, "R5");
    // R6: length zero, linear across the top of the space
    setup(2, 16'd0, 16'd0, 16'd1, 16'hFFFE);
    for (int k = 0; k < 4; k++) req(2, 0, 0, "R6");
    // R7: 3-bit window with upper bits kept, then full width (code 0)
    setup(3, 16'd0, 16'd0, 16'd4, 16'h1200);
    for (int k = 0; k < 9; k++) req(3, 1, 3, "R7");
    setup(4, 16'd0, 16'd0, 16'h8000, 16'h0000);
    for (int k = 0; k < 5; k++) req(4, 1, 0, "R7");
    // R8, R11: interleave two buffers back to back, then an idle cycle
    for (int k = 0; k < 4; k++) begin
      req(0, 0, 0, "R8");
      req(1, 0, 0, "R8");
    end
    idle(); idle();
    // R3: in-window step with no fold
    setup(6, 16'd40, 16'd20, 16'd5, 16'd41);
    req(6, 0, 0, "R3"); req(6, 0, 0, "R3");
    // R10: same-cycle index write beats the update
    req_and_write(6, 16'd55);
    req(6, 0, 0, "R10"); req(6, 0, 0, "R10");
    idle();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule